// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencing and Protection Logic

This block holds the digital control for a single hot-plug slot. It turns a main rail pair (12 V and 3.3 V, switched together) and a separate auxiliary rail on and off. It decides when a rail fault should latch the slot off, and it drives the slot's active-low power-good and fault indicators. Rail conditions reach it as synchronous digital flags for each rail group: current limit, undervoltage and overtemperature. A rail-ok vector reports which rails are actually delivering power.

The main and auxiliary groups each have their own enable, their own fault latch and their own current-limit filter counter. An enable acts on its rising edge, but only after power-on reset has completed. Driving an enable low switches that group off and clears that group's latch. An active-low force-on input serves as a diagnostic override. It can be masked by a register bit. While it is in effect, it powers every rail and bypasses all protection except auxiliary undervoltage. The indicator pins stay quiet during force-on, while the status bits keep reporting the true rail state.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, all rail enables are low and both `pwrgd_n` and `fault_n` are high. A rising edge of an enable, sampled at a clock edge while `por_done` is high, turns that group's rail enable on from the following cycle. That group's enable being low at a clock edge turns the rail off from the following cycle.
- R2: A rising edge of an enable seen while `por_done` is low is ignored. An enable that was already high when `por_done` rose does not turn its rail on until the enable goes low and rises again.
- R3: Current limit on a rail group that is on trips that group only after it has been sampled high on `FILT_CYC` consecutive clock edges. The group trips at the edge of the last of those samples. Any edge with current limit low restarts the count.
- R4: Undervoltage or overtemperature on a group that is on trips that group at the next clock edge.
- R5: A trip sets that group's fault latch, shown on `sts_main_fault` or `sts_aux_fault`. The main latch is cleared only by `main_en` being low at a clock edge. The aux latch is cleared only by `aux_en` being low at a clock edge. `fault_n` is low while either latch is set, so with both latches set, both enables must go low before it releases.
- R6: While a group's latch is set and force-on is not in effect, that group's rail enable stays off. It can turn on again only through an enable low (which clears the latch) followed by a fresh rising edge.
- R7: `rail_ok` bit 0 is the 12 V rail, bit 1 the 3.3 V rail and bit 2 the aux rail. Outside force-on, `pwrgd_n` is low exactly when both rail enables are on and all three `rail_ok` bits are high.
- R8: Force-on is in effect from the cycle after a clock edge that samples `force_on_n` low with `force_dis` low. While it is in effect, both main and aux rail enables are on regardless of enables, and current limit, overtemperature and main undervoltage set no latch. It also holds `pwrgd_n` and `fault_n` high.
- R9: While force-on is in effect, aux undervoltage still turns the aux rail enable off in the same cycle.
- R10: The status outputs (`sts_main_on`, `sts_aux_on`, `sts_pgood`, the two fault bits) report the true rail and latch state at all times, including during force-on.
- R11: With `force_dis` high, `force_on_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_done | input | 1 | Standby power-on-reset interval has elapsed |
| main_en | input | 1 | Main rail pair enable, rising-edge triggered |
| aux_en | input | 1 | Aux rail enable, rising-edge triggered |
| force_on_n | input | 1 | Diagnostic force-on, active low, level sensitive |
| force_dis | input | 1 | Register bit masking force_on_n |
| main_ilim | input | 1 | Main rails in current limit |
| main_uv | input | 1 | Main input undervoltage |
| main_ot | input | 1 | Main overtemperature |
| aux_ilim | input | 1 | Aux rail in current limit |
| aux_uv | input | 1 | Aux input undervoltage |
| aux_ot | input | 1 | Aux overtemperature |
| rail_ok | input | 3 | Rails delivering power: [0] 12 V, [1] 3.3 V, [2] aux |
| main_rail_en | output | 1 | Main rail pair switch enable |
| aux_rail_en | output | 1 | Aux rail switch enable |
| pwrgd_n | output | 1 | Power-good, active low |
| fault_n | output | 1 | Fault indicator, active low |
| sts_main_on | output | 1 | Status: main rail pair switched on |
| sts_aux_on | output | 1 | Status: aux rail switched on |
| sts_main_fault | output | 1 | Status: main fault latch |
| sts_aux_fault | output | 1 | Status: aux fault latch |
| sts_pgood | output | 1 | Status: all rails on and delivering |

## Verification
The bench builds the block with `FILT_CYC` = 6. A current-limit burst of five cycles (one short of a trip) and a burst of six (an exact trip) can then both be driven directly. Random current-limit bursts also cross the threshold often enough to exercise counter restarts alongside enable toggles. With a filter this short, force-on windows, latch clears and re-enable edges overlap within a few thousand random cycles. This brings combinations such as a trip on one group while the other group's latch is already set within reach.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int unsigned NUM_DOM  = 2;
  localparam int unsigned DOM_MAIN = 0;
  localparam int unsigned DOM_AUX  = 1;

  typedef struct packed {
    logic ilim;
    logic uv;
    logic ot;
  } rail_cond_t;
endpackage

// File: rtl/hp_oc_filter.sv
module hp_oc_filter #(
  parameter int unsigned FILT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ilim,
  output logic trip
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt;

  // consecutive-cycle counter, restarts on any quiet cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm && ilim) begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign trip = ilim && (cnt == LAST);
endmodule

// File: rtl/hp_rail_domain.sv
module hp_rail_domain
  import hp_slot_pkg::*;
#(
  parameter int unsigned FILT_CYC = 1000,
  parameter bit          KEEP_UV  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic       en,
  input  logic       force_act,
  input  rail_cond_t cond,
  output logic       rail_en,
  output logic       latched
);
  logic en_q, cmd, oc_trip, trip, rise;
  logic forced_trip, forced_en;

  hp_oc_filter #(.FILT_CYC(FILT_CYC)) u_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (cmd & ~force_act),
    .ilim (cond.ilim),
    .trip (oc_trip)
  );

  generate
    if (KEEP_UV) begin : g_keep_uv
      assign forced_trip = cond.uv;
      assign forced_en   = ~cond.uv;
    end else begin : g_drop_all
      assign forced_trip = 1'b0;
      assign forced_en   = 1'b1;
    end
  endgenerate

  assign trip = force_act ? forced_trip : (oc_trip | cond.uv | cond.ot);
  assign rise = en & ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cmd     <= 1'b0;
      latched <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) begin
        cmd     <= 1'b0;
        latched <= 1'b0;
      end else if (cmd && trip) begin
        cmd     <= 1'b0;
        latched <= 1'b1;
      end else if (rise && por_done && !latched) begin
        cmd <= 1'b1;
      end
    end
  end

  assign rail_en = force_act ? forced_en : cmd;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int unsigned FILT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic       main_en,
  input  logic       aux_en,
  input  logic       force_on_n,
  input  logic       force_dis,
  input  logic       main_ilim,
  input  logic       main_uv,
  input  logic       main_ot,
  input  logic       aux_ilim,
  input  logic       aux_uv,
  input  logic       aux_ot,
  input  logic [2:0] rail_ok,
  output logic       main_rail_en,
  output logic       aux_rail_en,
  output logic       pwrgd_n,
  output logic       fault_n,
  output logic       sts_main_on,
  output logic       sts_aux_on,
  output logic       sts_main_fault,
  output logic       sts_aux_fault,
  output logic       sts_pgood
);
  logic                force_q;
  logic [NUM_DOM-1:0]  en_v, rail_v, lat_v;
  rail_cond_t          conds [NUM_DOM];

  always_ff @(posedge clk) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= ~force_on_n & ~force_dis;
  end

  assign en_v[DOM_MAIN]  = main_en;
  assign en_v[DOM_AUX]   = aux_en;
  assign conds[DOM_MAIN] = '{ilim: main_ilim, uv: main_uv, ot: main_ot};
  assign conds[DOM_AUX]  = '{ilim: aux_ilim,  uv: aux_uv,  ot: aux_ot};

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      hp_rail_domain #(
        .FILT_CYC(FILT_CYC),
        .KEEP_UV (d == DOM_AUX)
      ) u_dom (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_done (por_done),
        .en       (en_v[d]),
        .force_act(force_q),
        .cond     (conds[d]),
        .rail_en  (rail_v[d]),
        .latched  (lat_v[d])
      );
    end
  endgenerate

  assign main_rail_en   = rail_v[DOM_MAIN];
  assign aux_rail_en    = rail_v[DOM_AUX];
  assign sts_main_on    = rail_v[DOM_MAIN];
  assign sts_aux_on     = rail_v[DOM_AUX];
  assign sts_main_fault = lat_v[DOM_MAIN];
  assign sts_aux_fault  = lat_v[DOM_AUX];
  assign sts_pgood      = (&rail_v) & (&rail_ok);
  assign pwrgd_n        = force_q | ~sts_pgood;
  assign fault_n        = force_q | ~(|lat_v);
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_q,
  input logic       main_en,
  input logic       aux_en,
  input logic       aux_uv,
  input logic [2:0] rail_ok,
  input logic       main_rail_en,
  input logic       aux_rail_en,
  input logic       pwrgd_n,
  input logic       fault_n,
  input logic       sts_main_fault,
  input logic       sts_aux_fault
);
  assert_en_low_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |=> (!main_rail_en || force_q));

  assert_main_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_main_fault && main_en) |=> sts_main_fault);

  assert_aux_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_aux_fault && aux_en) |=> sts_aux_fault);

  assert_latch_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_q && (sts_main_fault || sts_aux_fault)) |->
      !((sts_main_fault && main_rail_en) || (sts_aux_fault && aux_rail_en)));

  assert_pg_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrgd_n |-> (&rail_ok));

  assert_force_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> (pwrgd_n && fault_n));

  assert_force_aux_uv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && aux_uv) |-> !aux_rail_en);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .force_q       (force_q),
  .main_en       (main_en),
  .aux_en        (aux_en),
  .aux_uv        (aux_uv),
  .rail_ok       (rail_ok),
  .main_rail_en  (main_rail_en),
  .aux_rail_en   (aux_rail_en),
  .pwrgd_n       (pwrgd_n),
  .fault_n       (fault_n),
  .sts_main_fault(sts_main_fault),
  .sts_aux_fault (sts_aux_fault)
);

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int F = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, por, fon_n, fdis;
  logic [1:0] en, ilim, uv, ot;
  logic [2:0] rok;
  logic m_on, a_on, pg_n, f_n, s_mon, s_aon, s_mf, s_af, s_pg;

  int total = 0;
  int bad = 0;

  hp_slot_ctrl #(.FILT_CYC(F)) uut (
    .clk(clk), .rst_n(rst_n), .por_done(por),
    .main_en(en[0]), .aux_en(en[1]), .force_on_n(fon_n), .force_dis(fdis),
    .main_ilim(ilim[0]), .main_uv(uv[0]), .main_ot(ot[0]),
    .aux_ilim(ilim[1]), .aux_uv(uv[1]), .aux_ot(ot[1]),
    .rail_ok(rok),
    .main_rail_en(m_on), .aux_rail_en(a_on), .pwrgd_n(pg_n), .fault_n(f_n),
    .sts_main_on(s_mon), .sts_aux_on(s_aon), .sts_main_fault(s_mf),
    .sts_aux_fault(s_af), .sts_pgood(s_pg)
  );

  // behavioural model of the requirements
  logic       m_force;
  logic [1:0] m_cmd, m_lat, m_enq;
  int         m_cnt [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_force = 0; m_cmd = 0; m_lat = 0; m_enq = 0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        logic trip;
        trip = m_force ? (d == 1 && uv[d])
                       : ((ilim[d] && m_cnt[d] == F-1) || uv[d] || ot[d]);
        if (m_cmd[d] && ilim[d] && !m_force)
          m_cnt[d] = (m_cnt[d] < F-1) ? m_cnt[d] + 1 : m_cnt[d];
        else
          m_cnt[d] = 0;
        if (!en[d]) begin
          m_cmd[d] = 0; m_lat[d] = 0;
        end else if (m_cmd[d] && trip) begin
          m_cmd[d] = 0; m_lat[d] = 1;
        end else if (en[d] && !m_enq[d] && por && !m_lat[d]) begin
          m_cmd[d] = 1;
        end
        m_enq[d] = en[d];
      end
      m_force = !fon_n && !fdis;
    end
  end

  function automatic logic exp_on(int d);
    if (m_force) return (d == 1) ? !uv[1] : 1'b1;
    return m_cmd[d];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic pg;
    pg = exp_on(0) && exp_on(1) && (&rok);
    check("R1 main_rail_en", m_on, exp_on(0));
    check("R1 aux_rail_en", a_on, exp_on(1));
    check("R7 pwrgd_n", pg_n, m_force || !pg);
    check("R5 fault_n", f_n, m_force || !(m_lat[0] || m_lat[1]));
    check("R10 sts_main_on", s_mon, exp_on(0));
    check("R10 sts_aux_on", s_aon, exp_on(1));
    check("R5 sts_main_fault", s_mf, m_lat[0]);
    check("R5 sts_aux_fault", s_af, m_lat[1]);
    check("R10 sts_pgood", s_pg, pg);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cmp_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_5a0f));
    rst_n = 0; por = 0; fon_n = 1; fdis = 0;
    en = 0; ilim = 0; uv = 0; ot = 0; rok = 3'b111;
    ticks(3);
    check("R1 reset main off", m_on, 1'b0);
    check("R1 reset pwrgd_n", pg_n, 1'b1);
    check("R1 reset fault_n", f_n, 1'b1);
    rst_n = 1;
    tick();

    // R2: edge before por is ignored, high level after por does nothing
    en[0] = 1; tick();
    check("R2 edge before por", m_on, 1'b0);
    por = 1; ticks(2);
    check("R2 level after por", m_on, 1'b0);
    en[0] = 0; tick();
    en[0] = 1; tick();
    check("R1 main on after edge", m_on, 1'b1);
    en[1] = 1; tick();
    check("R1 aux on after edge", a_on, 1'b1);
    check("R7 pwrgd_n all good", pg_n, 1'b0);
    rok = 3'b101; tick();
    check("R7 pwrgd_n 3v3 missing", pg_n, 1'b1);
    rok = 3'b111;

    // R3: one cycle short of the filter, then exactly the filter
    ilim[0] = 1; ticks(F-1);
    ilim[0] = 0; tick();
    check("R3 short burst no trip", s_mf, 1'b0);
    check("R3 short burst still on", m_on, 1'b1);
    ilim[0] = 1; ticks(F-1);
    check("R3 not yet tripped", s_mf, 1'b0);
    tick();
    check("R3 trip at filter", s_mf, 1'b1);
    check("R6 main off when latched", m_on, 1'b0);
    ilim[0] = 0;

    // R4/R5: aux undervoltage; both latches need both enables low
    uv[1] = 1; tick();
    check("R4 aux uv trip", s_af, 1'b1);
    uv[1] = 0;
    en[0] = 0; tick();
    check("R5 main cleared", s_mf, 1'b0);
    check("R5 fault_n held by aux", f_n, 1'b0);
    en[0] = 1; tick();
    check("R6 main re-enabled", m_on, 1'b1);
    ticks(2);
    check("R6 aux stays off", a_on, 1'b0);
    en[1] = 0; tick();
    check("R5 fault_n released", f_n, 1'b1);
    en[1] = 1; tick();
    check("R6 aux re-enabled", a_on, 1'b1);

    // R8..R11: force-on
    fon_n = 0; tick();
    check("R8 force quiet fault_n", f_n, 1'b1);
    check("R8 force quiet pwrgd_n", pg_n, 1'b1);
    ot[0] = 1; uv[0] = 1; ticks(2);
    check("R8 main protections ignored", s_mf, 1'b0);
    check("R8 main forced on", m_on, 1'b1);
    ot[0] = 0; uv[0] = 0;
    en[0] = 0; tick();
    check("R8 forced on with enable low", m_on, 1'b1);
    check("R10 true pgood under force", s_pg, 1'b1);
    uv[1] = 1; #1;
    check("R9 aux uv under force", a_on, 1'b0);
    tick();
    check("R10 aux latch reported", s_af, 1'b1);
    uv[1] = 0; en[1] = 0; tick();
    en[1] = 1;
    fdis = 1; ticks(2);
    check("R11 force masked main", m_on, 1'b0);
    check("R11 fault_n released", f_n, 1'b1);
    fon_n = 1; fdis = 0; tick();

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      for (int d = 0; d < 2; d++) begin
        if ($urandom % 20 == 0) en[d] = ~en[d];
        if ($urandom % 5 == 0) ilim[d] = ~ilim[d];
        uv[d] = uv[d] ? ($urandom % 3 != 0) : ($urandom % 60 == 0);
        ot[d] = ot[d] ? ($urandom % 3 != 0) : ($urandom % 80 == 0);
      end
      if ($urandom % 70 == 0) fon_n = ~fon_n;
      if ($urandom % 150 == 0) fdis = ~fdis;
      if ($urandom % 200 == 0) por = ~por;
      rok = ($urandom % 10 == 0) ? 3'($urandom) : 3'b111;
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule